// File: doc/BRIEF.md
# Configurable Logic Cell with Dual Storage

This block models one configurable logic cell. Two 4-input lookup functions, F and G, each read a 16-bit truth-table word. A third 3-input lookup, H, combines the F result, the G result and one extra input. Output multiplexers set by configuration pick what drives two combinational outputs. They also pick the data input of each of two storage elements.

Each storage element is set up on its own as an edge-triggered flip-flop or as a level-sensitive latch. It has its own clock inversion, its own set/reset value, its own option to treat the shared enable as always on, and its own bypass path. Both elements share one clock pin, one clock enable and one set/reset pin. A global set/reset input loads every element with its configured value, at power-up or at any later time. All configuration arrives on static parallel ports and is held constant while the cell operates.

Top module: `cfg_logic_cell`

## Requirements
- R1: `fo` and `go` are not ports. F's result equals `cfg_f_tt[f_in]` and G's result equals `cfg_g_tt[g_in]`, with the input vector read as an unsigned bit index. Both are seen through `x`/`y` when the select picks them.
- R2: The H result equals `cfg_h_tt[idx]`, where idx = 4*h1 + 2*(G result) + (F result).
- R3: `x` follows `cfg_xsel` and `y` follows `cfg_ysel`. The codes are 0 for the F result, 1 for the G result, and 2 or 3 for the H result.
- R4: Element 0 drives `xq` and element 1 drives `yq`. Element i takes its data input from `cfg_dsel[2i+1:2i]`: 0 selects `din`, 1 the F result, 2 the G result and 3 the H result.
- R5: In flip-flop mode (`cfg_latch[i]`=0), element i captures its data on the rising edge of `k` when `cfg_clk_inv[i]`=0, or on the falling edge when it is 1, provided it is enabled.
- R6: Element i is enabled when `ec`=1 or `cfg_ec_tie[i]`=1. When it is not enabled, its stored value holds across clock edges of either direction.
- R7: In latch mode (`cfg_latch[i]`=1), element i is transparent while its effective clock (`k` XOR `cfg_clk_inv[i]`) is low and it is enabled. Otherwise it holds.
- R8: While `sr`=1, every element shows `cfg_srval[i]` at once, in either mode, whatever the clock and enable are doing. After `sr` falls the value holds until the next capture or transparent phase.
- R9: While `gsr`=1, every element loads `cfg_srval[i]`. This also sets the state after power-up.
- R10: With `cfg_bypass[i]`=1, the element's output shows its selected data input combinationally instead of the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_in | input | LUT_K | F lookup inputs |
| g_in | input | LUT_K | G lookup inputs |
| h1 | input | 1 | Extra input to the H lookup |
| din | input | 1 | Direct data input for the storage elements |
| k | input | 1 | Shared storage clock |
| ec | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared asynchronous set/reset |
| gsr | input | 1 | Global set/reset |
| cfg_f_tt | input | 2**LUT_K | F truth table |
| cfg_g_tt | input | 2**LUT_K | G truth table |
| cfg_h_tt | input | 8 | H truth table |
| cfg_xsel | input | 2 | Source select for x |
| cfg_ysel | input | 2 | Source select for y |
| cfg_dsel | input | 4 | Data-input select, two bits per element |
| cfg_clk_inv | input | 2 | Per-element clock inversion |
| cfg_latch | input | 2 | Per-element latch mode |
| cfg_srval | input | 2 | Per-element set/reset value |
| cfg_ec_tie | input | 2 | Per-element enable forced on |
| cfg_bypass | input | 2 | Per-element bypass of storage |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Element 0 output |
| yq | output | 1 | Element 1 output |

## Verification
The hardest cases to reach are the ones where timing inside a clock phase matters. One is an asynchronous set/reset that arrives partway through a phase. Another is two elements that share the clock pin but have opposite polarity, so one of them is transparent or capturing while the other is opaque. The bench drives `k` by hand instead of from a free-running clock, which lets it place `sr`, `gsr` and data changes inside a chosen level of `k`. After each step it checks both element outputs against a model kept in the bench. The combinational path is swept over every input combination for several truth tables, and every data-source code is swept with both bypasses on.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;

   typedef enum logic [1:0] {
      OSEL_F  = 2'd0,
      OSEL_G  = 2'd1,
      OSEL_H  = 2'd2,
      OSEL_HB = 2'd3
   } osel_e;

   typedef enum logic [1:0] {
      DSRC_DIN = 2'd0,
      DSRC_F   = 2'd1,
      DSRC_G   = 2'd2,
      DSRC_H   = 2'd3
   } dsrc_e;

   localparam int H_K     = 3;
   localparam int NUM_SE  = 2;

   function automatic logic pick_out(osel_e s, logic f, logic g, logic h);
      case (s)
         OSEL_F:  return f;
         OSEL_G:  return g;
         default: return h;
      endcase
   endfunction

   function automatic logic pick_d(dsrc_e s, logic d, logic f, logic g, logic h);
      case (s)
         DSRC_DIN: return d;
         DSRC_F:   return f;
         DSRC_G:   return g;
         default:  return h;
      endcase
   endfunction

endpackage

// File: rtl/lcell_lut.sv
`timescale 1ns/1ps
module lcell_lut #(
   parameter int K = 4,
   localparam int W = 1 << K
) (
   input  logic [W-1:0] tt,
   input  logic [K-1:0] sel,
   output logic         o
);

   if (K < 1 || K > 6) begin : g_bad_k
      $error("lcell_lut: K must lie in 1..6");
   end

   assign o = tt[sel];

endmodule

// File: rtl/lcell_store.sv
`timescale 1ns/1ps
module lcell_store (
   input  logic k,
   input  logic clk_inv,
   input  logic latch_mode,
   input  logic srval,
   input  logic ec,
   input  logic ec_tie,
   input  logic sr,
   input  logic gsr,
   input  logic d,
   output logic q
);

   logic clk_eff;
   logic sr_any;
   logic en;
   logic q_ff;
   logic q_lat;

   assign clk_eff = k ^ clk_inv;
   assign sr_any  = sr | gsr;
   assign en      = ec | ec_tie;

   // edge-triggered path
   always_ff @(posedge clk_eff or posedge sr_any) begin
      if (sr_any)  q_ff <= srval;
      else if (en) q_ff <= d;
   end

   // level-sensitive path, open while the effective clock is low
   always_latch begin
      if (sr_any)                 q_lat <= srval;
      else if (!clk_eff && en)    q_lat <= d;
   end

   assign q = latch_mode ? q_lat : q_ff;

   // checker state: value the flop is expected to show after the edge
   logic chk_vld;
   logic chk_q;
   always_ff @(posedge clk_eff or posedge sr_any) begin
      if (sr_any) begin
         chk_vld <= 1'b0;
         chk_q   <= 1'b0;
      end else begin
         chk_vld <= !latch_mode;
         chk_q   <= en ? d : q_ff;
      end
   end

   AST_FF_TRACK: assert property (@(negedge clk_eff) disable iff (sr_any)
      chk_vld |-> (q == chk_q)); // R5 R6

   AST_LATCH_FOLLOW: assert property (@(posedge clk_eff) disable iff (sr_any)
      (latch_mode && en) |-> (q == d)); // R7

endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
module cfg_logic_cell
   import lcell_pkg::*;
#(
   parameter int  LUT_K      = 4,
   parameter bit  HAS_BYPASS = 1'b1,
   localparam int TT_W       = 1 << LUT_K
) (
   input  logic [LUT_K-1:0] f_in,
   input  logic [LUT_K-1:0] g_in,
   input  logic             h1,
   input  logic             din,
   input  logic             k,
   input  logic             ec,
   input  logic             sr,
   input  logic             gsr,
   input  logic [TT_W-1:0]  cfg_f_tt,
   input  logic [TT_W-1:0]  cfg_g_tt,
   input  logic [7:0]       cfg_h_tt,
   input  logic [1:0]       cfg_xsel,
   input  logic [1:0]       cfg_ysel,
   input  logic [3:0]       cfg_dsel,
   input  logic [1:0]       cfg_clk_inv,
   input  logic [1:0]       cfg_latch,
   input  logic [1:0]       cfg_srval,
   input  logic [1:0]       cfg_ec_tie,
   input  logic [1:0]       cfg_bypass,
   output logic             x,
   output logic             y,
   output logic             xq,
   output logic             yq
);

   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("cfg_logic_cell: LUT_K must lie in 2..6");
   end
   if (NUM_SE != 2) begin : g_bad_se
      $error("cfg_logic_cell: exactly two storage elements expected");
   end

   logic f_o;
   logic g_o;
   logic h_o;

   lcell_lut #(.K(LUT_K)) u_f (.tt(cfg_f_tt), .sel(f_in), .o(f_o));
   lcell_lut #(.K(LUT_K)) u_g (.tt(cfg_g_tt), .sel(g_in), .o(g_o));
   lcell_lut #(.K(H_K))   u_h (.tt(cfg_h_tt), .sel({h1, g_o, f_o}), .o(h_o));

   assign x = pick_out(osel_e'(cfg_xsel), f_o, g_o, h_o);
   assign y = pick_out(osel_e'(cfg_ysel), f_o, g_o, h_o);

   logic [NUM_SE-1:0] se_d;
   logic [NUM_SE-1:0] se_q;
   logic [NUM_SE-1:0] se_out;

   for (genvar i = 0; i < NUM_SE; i++) begin : g_se
      assign se_d[i] = pick_d(dsrc_e'(cfg_dsel[2*i +: 2]), din, f_o, g_o, h_o);

      lcell_store u_st (
         .k          (k),
         .clk_inv    (cfg_clk_inv[i]),
         .latch_mode (cfg_latch[i]),
         .srval      (cfg_srval[i]),
         .ec         (ec),
         .ec_tie     (cfg_ec_tie[i]),
         .sr         (sr),
         .gsr        (gsr),
         .d          (se_d[i]),
         .q          (se_q[i])
      );

      if (HAS_BYPASS) begin : g_byp
         assign se_out[i] = cfg_bypass[i] ? se_d[i] : se_q[i];
      end else begin : g_nobyp
         assign se_out[i] = se_q[i];
      end
   end

   assign xq = se_out[0];
   assign yq = se_out[1];

   AST_SR_FORCE_X: assert property (@(posedge k) disable iff (gsr)
      (sr && !cfg_bypass[0]) |-> (xq == cfg_srval[0])); // R8

   AST_SR_FORCE_Y: assert property (@(posedge k) disable iff (gsr)
      (sr && !cfg_bypass[1]) |-> (yq == cfg_srval[1])); // R8

   AST_BYPASS_Y: assert property (@(posedge k) disable iff (gsr)
      cfg_bypass[1] |-> (yq == se_d[1])); // R10

endmodule

// File: tb/sim_cfg_logic_cell.sv
`timescale 1ns/1ps
module sim_cfg_logic_cell;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [3:0]  f_in = '0, g_in = '0;
   logic        h1 = 0, din = 0, k = 0, ec = 1, sr = 0, gsr = 1;
   logic [15:0] cfg_f_tt = '0, cfg_g_tt = '0;
   logic [7:0]  cfg_h_tt = '0;
   logic [1:0]  cfg_xsel = 0, cfg_ysel = 0;
   logic [3:0]  cfg_dsel = 0;
   logic [1:0]  cfg_clk_inv = 2'b10, cfg_latch = 0, cfg_srval = 2'b10;
   logic [1:0]  cfg_ec_tie = 0, cfg_bypass = 0;
   logic        x, y, xq, yq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   cfg_logic_cell u0 (
      .f_in(f_in), .g_in(g_in), .h1(h1), .din(din), .k(k), .ec(ec), .sr(sr), .gsr(gsr),
      .cfg_f_tt(cfg_f_tt), .cfg_g_tt(cfg_g_tt), .cfg_h_tt(cfg_h_tt),
      .cfg_xsel(cfg_xsel), .cfg_ysel(cfg_ysel), .cfg_dsel(cfg_dsel),
      .cfg_clk_inv(cfg_clk_inv), .cfg_latch(cfg_latch), .cfg_srval(cfg_srval),
      .cfg_ec_tie(cfg_ec_tie), .cfg_bypass(cfg_bypass),
      .x(x), .y(y), .xq(xq), .yq(yq)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   function automatic logic sel_out(input logic [1:0] s, input logic f, input logic g, input logic h);
      return (s == 2'd0) ? f : (s == 2'd1) ? g : h;
   endfunction

   function automatic logic sel_d(input logic [1:0] s, input logic d, input logic f, input logic g, input logic h);
      return (s == 2'd0) ? d : (s == 2'd1) ? f : (s == 2'd2) ? g : h;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic ex, ey, r, s2;
      // R9: power-up load, srval 10 -> xq 0, yq 1
      #3;
      chk(xq, 1'b0, "R9 reset xq");
      chk(yq, 1'b1, "R9 reset yq");
      gsr = 0; #1;
      chk(xq, 1'b0, "R9 after release xq");
      chk(yq, 1'b1, "R9 after release yq");

      // R1 R2 R3: combinational sweep, storage untouched (ec low, k still)
      ec = 0;
      for (int t = 0; t < 4; t++) begin
         cfg_f_tt = (t == 0) ? 16'h6996 : 16'($urandom);
         cfg_g_tt = (t == 0) ? 16'hFF00 : 16'($urandom);
         cfg_h_tt = (t == 0) ? 8'hE8    : 8'($urandom);
         for (int v = 0; v < 512; v++) begin
            logic [8:0] vv;
            logic ef, eg, eh;
            vv = 9'(v);
            f_in = vv[3:0]; g_in = vv[7:4]; h1 = vv[8];
            cfg_xsel = vv[1:0] ^ 2'(t);
            cfg_ysel = vv[5:4];
            #1;
            ef = cfg_f_tt[vv[3:0]];
            eg = cfg_g_tt[vv[7:4]];
            eh = cfg_h_tt[{vv[8], eg, ef}];
            chk(x, sel_out(cfg_xsel, ef, eg, eh), "R1 R2 R3 x");
            chk(y, sel_out(cfg_ysel, ef, eg, eh), "R1 R2 R3 y");
            #1;
         end
      end

      // R4 R10: every data-source code seen through bypass
      cfg_bypass = 2'b11;
      for (int sd = 0; sd < 16; sd++) begin
         for (int j = 0; j < 16; j++) begin
            logic ef, eg, eh;
            cfg_dsel = 4'(sd);
            f_in = 4'($urandom); g_in = 4'($urandom); h1 = 1'($urandom); din = 1'($urandom);
            #1;
            ef = cfg_f_tt[f_in]; eg = cfg_g_tt[g_in]; eh = cfg_h_tt[{h1, eg, ef}];
            chk(xq, sel_d(cfg_dsel[1:0], din, ef, eg, eh), "R4 R10 xq");
            chk(yq, sel_d(cfg_dsel[3:2], din, ef, eg, eh), "R4 R10 yq");
            #1;
         end
      end

      // R5: flip-flops, element 0 rising, element 1 falling
      cfg_bypass = 0; cfg_dsel = 0; cfg_latch = 0; cfg_srval = 2'b00; ec = 1;
      gsr = 1; #1; gsr = 0; #1;
      ex = 0; ey = 0;
      for (int j = 0; j < 8; j++) begin
         r = 1'($urandom); s2 = ~r;
         din = r; #1; k = 1; #1;
         ex = r;
         chk(xq, ex, "R5 rising capture xq");
         chk(yq, ey, "R5 hold on rising yq");
         din = s2; #1; k = 0; #1;
         ey = s2;
         chk(xq, ex, "R5 hold on falling xq");
         chk(yq, ey, "R5 falling capture yq");
      end

      // R6: enable low holds both; tie forces element 0 only
      ec = 0;
      for (int j = 0; j < 4; j++) begin
         din = ~din; #1; k = 1; #1; din = ~din; #1; k = 0; #1;
         chk(xq, ex, "R6 disabled hold xq");
         chk(yq, ey, "R6 disabled hold yq");
      end
      cfg_ec_tie = 2'b01;
      din = ~ex; #1; k = 1; #1; ex = din;
      chk(xq, ex, "R6 tied enable capture xq");
      din = ~ey; #1; k = 0; #1;
      chk(yq, ey, "R6 untied hold yq");
      cfg_ec_tie = 0; ec = 1;

      // R7: latches, element 0 open while k low, element 1 while k high
      cfg_latch = 2'b11; k = 0; din = 1; #1;
      gsr = 1; #1; gsr = 0; #1;
      ex = 1; ey = 0;
      chk(xq, ex, "R7 open latch after release xq");
      chk(yq, ey, "R7 closed latch yq");
      for (int j = 0; j < 6; j++) begin
         r = 1'($urandom);
         din = r; #1; ex = r;
         chk(xq, ex, "R7 follow while k low xq");
         chk(yq, ey, "R7 hold while k low yq");
         k = 1; #1; ey = r;
         din = ~r; #1; ey = ~r;
         chk(xq, ex, "R7 hold while k high xq");
         chk(yq, ey, "R7 follow while k high yq");
         k = 0; #1; ex = din;
         chk(xq, ex, "R7 reopen xq");
      end
      ec = 0; din = ~din; #1;
      chk(xq, ex, "R7 enable low closes latch xq");
      ec = 1; #1; ex = din;
      chk(xq, ex, "R7 enable high reopens xq");

      // R8: sr mid-phase in flip-flop mode
      cfg_latch = 0; cfg_srval = 2'b01;
      din = 0; #1; k = 1; #1; din = 1; #1; k = 0; #1;
      chk(xq, 1'b0, "R8 preload xq");
      chk(yq, 1'b1, "R8 preload yq");
      k = 1; #1; sr = 1; #1;
      chk(xq, 1'b1, "R8 force mid-phase xq");
      chk(yq, 1'b0, "R8 force mid-phase yq");
      din = 0; #1; k = 0; #1; din = 1; #1; k = 1; #1;
      chk(xq, 1'b1, "R8 force over edges xq");
      chk(yq, 1'b0, "R8 force over edges yq");
      k = 0; #1; sr = 0; #1;
      chk(xq, 1'b1, "R8 hold after release xq");
      chk(yq, 1'b0, "R8 hold after release yq");
      din = 0; #1; k = 1; #1;
      chk(xq, 1'b0, "R8 capture after release xq");

      // R8: sr in latch mode overrides an open latch
      cfg_latch = 2'b11; k = 0; din = 0; #1;
      sr = 1; #1;
      chk(xq, 1'b1, "R8 latch force xq");
      chk(yq, 1'b0, "R8 latch force yq");
      sr = 0; #1;
      chk(xq, 1'b0, "R8 latch reopens xq");
      chk(yq, 1'b0, "R8 closed latch keeps forced yq");

      // R9: global set/reset mid-run with new values
      cfg_latch = 0; cfg_srval = 2'b10; k = 1; #1;
      gsr = 1; #1;
      chk(xq, 1'b0, "R9 global load xq");
      chk(yq, 1'b1, "R9 global load yq");
      gsr = 0; #1;
      chk(xq, 1'b0, "R9 hold after global xq");
      chk(yq, 1'b1, "R9 hold after global yq");

      finish_run();
   end

endmodule